// File: doc/BRIEF.md
# Event-Driven State Sequencer

This block holds the small state variable of a configurable timer and moves it when timer events occur. Six event-match strobes come in each clock cycle from the match logic outside. Each event carries a 32-bit state mask with one bit per state. An event may take effect only in the states whose bits are set. Each event also carries a 5-bit update value and a load flag. With the flag set, the update replaces the state. With the flag clear, the value is added to the state modulo 32. When several permitted events fire in one cycle, only the highest-numbered one decides the update. A halt input stops all event activity.

Software programs the masks, the update words and the initial state through a simple write-only register port. Each cycle the block reports two things: which events the current state permits, and which events actually fired against the state in effect before the update. The state register changes on the clock edge that follows. The reset input is assumed to arrive already synchronised to the clock on release.

Top module: `evt_state_seq`

## Requirements
- R1: After reset the state is 0 and every event mask and update word is 0, so `evt_allow` reads 0.
- R2: `evt_allow[i]` equals bit `state` of event i's mask. An event whose mask bit for the current state is clear does not fire and does not move the state.
- R3: `evt_fired` equals `evt_match & evt_allow` in the same cycle when `halt` is low, and reflects the state before any update.
- R4: When several events fire together, only the highest-numbered fired event updates the state, and lower-numbered fired events have no effect on it. This holds even when the highest event's update leaves the state unchanged.
- R5: If the winning event's load flag is 1, the state becomes that event's value on the next clock edge.
- R6: If the winning event's load flag is 0, the state becomes (state + value) mod 32 on the next clock edge.
- R7: A winning event with value 0 and load flag 0 leaves the state unchanged, while it is still reported in `evt_fired`.
- R8: While `halt` is high, `evt_fired` is 0 and events do not change the state.
- R9: A write to address 15 loads `cfg_wdata[4:0]` into the state on the next edge and takes priority over any event in the same cycle.
- R10: Register map: address i (0 to 5) holds event i's mask (`cfg_wdata[31:0]`, bit s enables state s). Address 8+i holds event i's update word, with value in bits [4:0] and load flag in bit 5. Writes to the other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| halt | input | 1 | Counter halted; suppresses every event |
| evt_match | input | 6 | Per-event match strobes for this cycle |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| state | output | 5 | Current state |
| evt_allow | output | 6 | Events permitted in the current state |
| evt_fired | output | 6 | Events that matched, were permitted and were not halted |

## Verification
A wrong state value shows up at once on `evt_allow`, because the mask bit is picked by the state. It also shows on the `state` port one edge after the faulty update. A wrong choice of winner or a wrong add/load choice shows as a wrong `state` on the edge that follows the firing cycle. The wrap case, the zero-update case and the same-cycle software write are each driven, so an error there shows within one cycle. Stored masks that were corrupted by a write to an unused address show as a wrong `evt_allow` in the next state that uses them.

// File: rtl/evs_pkg.sv
package evs_pkg;
  parameter int EVS_N_EVT      = 6;
  parameter int EVS_ST_W       = 5;
  parameter int EVS_AW         = 4;
  parameter int EVS_DW         = 32;
  parameter int EVS_CTRL_BASE  = 8;
  parameter int EVS_STATE_ADDR = 15;
endpackage

// File: rtl/evs_cfg_regs.sv
module evs_cfg_regs #(
  parameter int N_EVT      = evs_pkg::EVS_N_EVT,
  parameter int ST_W       = evs_pkg::EVS_ST_W,
  parameter int AW         = evs_pkg::EVS_AW,
  parameter int DW         = evs_pkg::EVS_DW,
  parameter int CTRL_BASE  = evs_pkg::EVS_CTRL_BASE,
  parameter int STATE_ADDR = evs_pkg::EVS_STATE_ADDR,
  localparam int N_ST      = 1 << ST_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wdata,
  output logic [N_EVT-1:0][N_ST-1:0]     mask_o,
  output logic [N_EVT-1:0][ST_W-1:0]     val_o,
  output logic [N_EVT-1:0]               ld_o,
  output logic                           st_wr_o,
  output logic [ST_W-1:0]                st_wdata_o
);
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    logic            mask_we, ctrl_we;
    logic [N_ST-1:0] mask_q, mask_d;
    logic [ST_W-1:0] val_q, val_d;
    logic            ld_q, ld_d;

    always_comb begin
      mask_we = wr_en && (addr == AW'(g));
      ctrl_we = wr_en && (addr == AW'(CTRL_BASE + g));
      mask_d  = mask_we ? wdata[N_ST-1:0] : mask_q;
      val_d   = ctrl_we ? wdata[ST_W-1:0] : val_q;
      ld_d    = ctrl_we ? wdata[ST_W]     : ld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        val_q  <= '0;
        ld_q   <= 1'b0;
      end else begin
        if (mask_we) mask_q <= mask_d;
        if (ctrl_we) begin
          val_q <= val_d;
          ld_q  <= ld_d;
        end
      end
    end

    assign mask_o[g] = mask_q;
    assign val_o[g]  = val_q;
    assign ld_o[g]   = ld_q;
  end

  assign st_wr_o    = wr_en && (addr == AW'(STATE_ADDR));
  assign st_wdata_o = wdata[ST_W-1:0];

  // R10: without a write strobe no configuration changes
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_o) && $stable(val_o) && $stable(ld_o)));
endmodule

// File: rtl/evs_evt_select.sv
module evs_evt_select #(
  parameter int N_EVT = evs_pkg::EVS_N_EVT,
  parameter int ST_W  = evs_pkg::EVS_ST_W,
  localparam int N_ST  = 1 << ST_W,
  localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ST_W-1:0]            state_i,
  input  logic [N_EVT-1:0][N_ST-1:0] mask_i,
  input  logic [N_EVT-1:0]           match_i,
  input  logic                       halt_i,
  output logic [N_EVT-1:0]           allow_o,
  output logic [N_EVT-1:0]           fired_o,
  output logic                       win_any_o,
  output logic [IDX_W-1:0]           win_idx_o
);
  for (genvar g = 0; g < N_EVT; g++) begin : g_allow
    assign allow_o[g] = mask_i[g][state_i];
  end

  always_comb begin
    fired_o   = match_i & allow_o & {N_EVT{~halt_i}};
    win_any_o = |fired_o;
    win_idx_o = '0;
    for (int i = 0; i < N_EVT; i++) begin
      if (fired_o[i]) win_idx_o = IDX_W'(i);
    end
  end

  // R4: the chosen event has fired and no higher-numbered one has
  p_win_highest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_any_o |-> ((fired_o >> win_idx_o) == N_EVT'(1)));
endmodule

// File: rtl/evs_state_reg.sv
module evs_state_reg #(
  parameter int N_EVT = evs_pkg::EVS_N_EVT,
  parameter int ST_W  = evs_pkg::EVS_ST_W,
  localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_any_i,
  input  logic [IDX_W-1:0]           win_idx_i,
  input  logic [N_EVT-1:0][ST_W-1:0] val_i,
  input  logic [N_EVT-1:0]           ld_i,
  input  logic                       st_wr_i,
  input  logic [ST_W-1:0]            st_wdata_i,
  output logic [ST_W-1:0]            state_o
);
  logic [ST_W-1:0] state_q, state_d, sel_val;
  logic            sel_ld, state_en;

  always_comb begin
    sel_val  = val_i[win_idx_i];
    sel_ld   = ld_i[win_idx_i];
    state_en = st_wr_i || win_any_i;
    if (st_wr_i)        state_d = st_wdata_i;
    else if (win_any_i) state_d = sel_ld ? sel_val : ST_W'(state_q + sel_val);
    else                state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R9: software write lands on the next edge
  p_sw_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_i |=> (state_o == $past(st_wdata_i)));
  // R8: nothing fired and no write keeps the state
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr_i && !win_any_i) |=> $stable(state_o));
  // R5: load replaces the state
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr_i && win_any_i && sel_ld) |=> (state_o == $past(sel_val)));
  // R6: add wraps modulo the state count
  p_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr_i && win_any_i && !sel_ld) |=> (state_o == ST_W'($past(state_o) + $past(sel_val))));
endmodule

// File: rtl/evt_state_seq.sv
module evt_state_seq #(
  parameter int N_EVT = evs_pkg::EVS_N_EVT,
  parameter int ST_W  = evs_pkg::EVS_ST_W,
  parameter int AW    = evs_pkg::EVS_AW,
  parameter int DW    = evs_pkg::EVS_DW,
  localparam int N_ST  = 1 << ST_W,
  localparam int IDX_W = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [N_EVT-1:0] evt_match,
  input  logic             cfg_wr,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [ST_W-1:0]  state,
  output logic [N_EVT-1:0] evt_allow,
  output logic [N_EVT-1:0] evt_fired
);
  logic [N_EVT-1:0][N_ST-1:0] mask;
  logic [N_EVT-1:0][ST_W-1:0] val;
  logic [N_EVT-1:0]           ld;
  logic                       st_wr, win_any;
  logic [ST_W-1:0]            st_wdata;
  logic [IDX_W-1:0]           win_idx;

  evs_cfg_regs #(.N_EVT(N_EVT), .ST_W(ST_W), .AW(AW), .DW(DW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .mask_o(mask), .val_o(val), .ld_o(ld), .st_wr_o(st_wr), .st_wdata_o(st_wdata)
  );

  evs_evt_select #(.N_EVT(N_EVT), .ST_W(ST_W)) i_sel (
    .clk(clk), .rst_n(rst_n), .state_i(state), .mask_i(mask), .match_i(evt_match),
    .halt_i(halt), .allow_o(evt_allow), .fired_o(evt_fired),
    .win_any_o(win_any), .win_idx_o(win_idx)
  );

  evs_state_reg #(.N_EVT(N_EVT), .ST_W(ST_W)) i_st (
    .clk(clk), .rst_n(rst_n), .win_any_i(win_any), .win_idx_i(win_idx),
    .val_i(val), .ld_i(ld), .st_wr_i(st_wr), .st_wdata_i(st_wdata), .state_o(state)
  );

  // R8: halt silences every event at the ports
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (evt_fired == '0));
  // R3: fired events are a subset of both matches and permitted events
  p_fired_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_fired & ~(evt_match & evt_allow)) == '0));
endmodule

// File: tb/test_evt_state_seq.sv
`timescale 1ns/1ps
module test_evt_state_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic [5:0]  evt_match = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  state;
  logic [5:0]  evt_allow, evt_fired;

  always #4 clk = ~clk;  // 125 MHz

  evt_state_seq i_evt_state_seq (
    .clk(clk), .rst_n(rst_n), .halt(halt), .evt_match(evt_match),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .state(state), .evt_allow(evt_allow), .evt_fired(evt_fired)
  );

  typedef struct {
    logic [5:0] allow;
    logic [5:0] fired;
    logic [4:0] st;
    int         req;
  } item_t;

  item_t       q[$];
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  // reference model of the requirements
  logic [31:0] m_mask [6];
  logic [4:0]  m_val  [6];
  logic        m_ld   [6];
  logic [4:0]  m_st;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] m, input logic h, input logic w,
                       input logic [3:0] a, input logic [31:0] d, input int req);
    item_t it;
    logic [5:0] al, fi;
    int win;
    @(negedge clk);
    evt_match = m; halt = h; cfg_wr = w; cfg_addr = a; cfg_wdata = d;
    for (int i = 0; i < 6; i++) al[i] = m_mask[i][m_st];
    fi = m & al & {6{~h}};
    win = -1;
    for (int i = 0; i < 6; i++) if (fi[i]) win = i;
    it.allow = al; it.fired = fi; it.req = req;
    if (w && a == 4'd15)  it.st = d[4:0];
    else if (win >= 0)    it.st = m_ld[win] ? m_val[win] : 5'(m_st + m_val[win]);
    else                  it.st = m_st;
    q.push_back(it);
    m_st = it.st;
    if (w) begin
      if (a < 4'd6) m_mask[a] = d;
      else if (a >= 4'd8 && a < 4'd14) begin
        m_val[a - 4'd8] = d[4:0];
        m_ld[a - 4'd8]  = d[5];
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(6'd0, 1'b0, 1'b1, a, d, 10);  // R10 configuration cycle
  endtask

  // monitor: pops expected items and compares
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() != 0) begin
        it = q.pop_front();
        check(it.req, 32'(evt_allow), 32'(it.allow), "evt_allow");
        check(it.req, 32'(evt_fired), 32'(it.fired), "evt_fired");
        @(posedge clk);
        #1;
        check(it.req, 32'(state), 32'(it.st), "state");
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_mask[i] = '0; m_val[i] = '0; m_ld[i] = 1'b0; end
    m_st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(1, 32'(state), 32'd0, "state after reset");      // R1
    check(1, 32'(evt_allow), 32'd0, "allow after reset");  // R1
    // R10 map: masks at 0..5, update words at 8..13 (bit5 load)
    wr(4'd0, 32'h0000_0001);  wr(4'd8,  32'h03);
    wr(4'd1, 32'h0000_0008);  wr(4'd9,  32'h2A);
    wr(4'd2, 32'h0004_0400);  wr(4'd10, 32'h21);
    wr(4'd3, 32'h0004_0000);  wr(4'd11, 32'h00);
    wr(4'd4, 32'h4000_0400);  wr(4'd12, 32'h14);
    wr(4'd5, 32'hFFFF_FFFF);  wr(4'd13, 32'h01);
    wr(4'd7, 32'hFFFF_FFFF);  wr(4'd14, 32'h3F);   // R10 unused addresses
    drive(6'h01, 0, 0, 0, 0, 6);   // R6: 0 + 3 -> 3
    drive(6'h01, 0, 0, 0, 0, 2);   // R2: event 0 not permitted in state 3
    drive(6'h02, 0, 0, 0, 0, 5);   // R5: load 10
    drive(6'h14, 0, 0, 0, 0, 4);   // R4: events 2 and 4, 4 wins -> 30
    drive(6'h10, 0, 0, 0, 0, 6);   // R6: 30 + 20 wraps to 18
    drive(6'h08, 0, 0, 0, 0, 7);   // R7: zero update keeps 18
    drive(6'h0C, 0, 0, 0, 0, 4);   // R4: event 3 outranks event 2
    drive(6'h3F, 1, 0, 0, 0, 8);   // R8: halted
    drive(6'h20, 0, 0, 0, 0, 3);   // R3: event 5 adds 1 -> 19
    drive(6'h20, 0, 1, 4'd15, 32'd7, 9);   // R9: write beats event
    drive(6'h00, 0, 1, 4'd15, 32'd31, 9);  // R9: write 31
    drive(6'h20, 0, 0, 0, 0, 6);   // R6: 31 + 1 wraps to 0
    drive(6'h00, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule